// File: doc/BRIEF.md
# Four-Channel Serial DAC Update Sequencer

This block sits on the host side of a four-channel serial DAC. It takes one write request at a time on a valid/ready interface. Each request carries a channel number and a 14-bit code. The block packs them into a 24-bit word and shifts that word out as three back-to-back 8-bit transfers. A frame-sync output is held low across all three transfers.

Once the frame is closed, the load strobe is pulsed according to the update policy. In immediate mode, every frame is followed by its own pulse. In batch mode, a single pulse is issued once every channel has been written since the previous pulse. A separate clear strobe is driven low for a fixed time on command, and it runs alongside any frame without disturbing it.

The serial clock is the system clock divided by the even ratio `DIV`, which must be at least 4. `LOAD_LEN` and `CLR_LEN` must each be at least 2.

The sequencer is built from five states:
- `ST_IDLE`: ready for a request.
- `ST_SYNC`: frame sync is low and the setup half period is being counted.
- `ST_SHIFT`: a byte is in flight.
- `ST_RISE`: frame sync is high and one serial period is being counted.
- `ST_LOAD`: the load strobe is active.

Its transitions are:
- IDLE to SYNC when a request is accepted.
- SYNC to SHIFT when the half period ends and byte 0 starts.
- SHIFT to SHIFT when a byte ends that is not the last one, and the next byte starts.
- SHIFT to RISE when the last byte ends.
- RISE to LOAD when the period ends and a pulse is due.
- RISE to IDLE when the period ends and no pulse is due.
- LOAD to IDLE when the pulse ends.

Top module: `quad_dac_writer`

## Requirements
- R1: After reset, `frame_n`, `load_n` and `clear_n` are high, `ser_clk` is low and `req_ready` is high.
- R2: The 24-bit word carries the channel in bits 21:20, the code in bits 13:0, and zeros in every other bit. It is sent most significant bit first as three bytes, with exactly 8 falling `ser_clk` edges per byte and 24 per frame.
- R3: `ser_clk` has a period of `DIV` system clocks. `ser_dat` does not change while `ser_clk` is high, nor on the cycle in which `ser_clk` falls.
- R4: `ser_clk` idles low and toggles only while `frame_n` is low. `frame_n` falls at least `DIV/2` cycles before the first rising `ser_clk` edge, and rises only after the 24th falling edge.
- R5: With `batch_mode` = 0, each frame is followed by exactly one load pulse.
- R6: With `batch_mode` = 1, no load pulse is issued until each of the four channels has been written at least once since the last pulse. Rewriting a channel does not count twice. One pulse follows the frame that completes the set.
- R7: The load pulse (`load_n` low) lasts `LOAD_LEN` cycles. It begins at least `DIV` cycles after `frame_n` rises and never overlaps a frame.
- R8: `req_ready` is low from the cycle after acceptance until the frame, and any load pulse, has ended. `req_valid` is ignored while `req_ready` is low.
- R9: A `clr_cmd` pulse drives `clear_n` low from the next cycle for exactly `CLR_LEN` cycles, and a frame in progress is sent unchanged.
- R10: A `clr_cmd` arriving while `clear_n` is already low is ignored and does not lengthen the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_chan | input | 2 | Target channel |
| req_code | input | 14 | Code for the channel |
| batch_mode | input | 1 | 0: pulse after each frame, 1: pulse after all four channels |
| clr_cmd | input | 1 | One-cycle clear command |
| ser_clk | output | 1 | Serial clock to the DAC |
| ser_dat | output | 1 | Serial data to the DAC |
| frame_n | output | 1 | Active-low frame sync |
| load_n | output | 1 | Active-low load strobe |
| clear_n | output | 1 | Active-low clear strobe |

## Verification
The assertions rely on the parameter limits given above: an even `DIV` of at least 4, so that the data shift falls one cycle after each clock fall, and strobe lengths of at least 2, so that a strobe is still low on the cycle after it falls. They also rely on `batch_mode` being held steady while a frame is in flight. The stimulus sets the mode only while `req_ready` is high and keeps the default parameters. The bench drives `clr_cmd` as single-cycle pulses, and it drives requests only on falling clock edges.

// File: rtl/qdw_pkg.sv
package qdw_pkg;
    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 3;
    localparam int WORD_W      = BYTE_W * FRAME_BYTES;
    localparam int CHAN_W      = 2;
    localparam int N_CHAN      = 1 << CHAN_W;
    localparam int CODE_W      = 14;
    localparam int CHAN_LSB    = 20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_SHIFT,
        ST_RISE,
        ST_LOAD
    } seq_state_t;

    function automatic logic [WORD_W-1:0] pack_word(input logic [CHAN_W-1:0] ch,
                                                    input logic [CODE_W-1:0] code);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CHAN_LSB +: CHAN_W] = ch;
        w[CODE_W-1:0] = code;
        return w;
    endfunction
endpackage

// File: rtl/qdw_shifter.sv
module qdw_shifter #(
    parameter int HALF   = 2,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int HC_W  = $clog2(HALF + 1);
    localparam int BIT_W = $clog2(BYTE_W);

    logic [HC_W-1:0]   hc;
    logic [BIT_W-1:0]  bitn;
    logic [BYTE_W-1:0] sh;
    logic              ph;
    logic              adv;
    logic              busy;

    // Each bit: low phase then high phase; data moves one cycle after a fall.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc     <= '0;
            bitn   <= '0;
            sh     <= '0;
            ph     <= 1'b0;
            adv    <= 1'b0;
            busy   <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!busy && start_i) begin
                busy <= 1'b1;
                sh   <= byte_i;
                bitn <= '0;
                ph   <= 1'b0;
                hc   <= '0;
                adv  <= 1'b0;
            end else if (busy) begin
                if (adv) begin
                    sh  <= sh << 1;
                    adv <= 1'b0;
                end
                if (hc == HC_W'(HALF - 1)) begin
                    hc <= '0;
                    if (!ph) begin
                        ph <= 1'b1;
                    end else begin
                        ph <= 1'b0;
                        if (bitn == BIT_W'(BYTE_W - 1)) begin
                            busy   <= 1'b0;
                            done_o <= 1'b1;
                        end else begin
                            bitn <= bitn + 1'b1;
                            adv  <= 1'b1;
                        end
                    end
                end else begin
                    hc <= hc + 1'b1;
                end
            end
        end
    end

    assign sclk_o = ph;
    assign sdo_o  = sh[BYTE_W-1];
    assign busy_o = busy;

    // R3: the data bit must hold across the falling clock edge
    a_r3_hold_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ph) |-> $stable(sh[BYTE_W-1]));

    // R4: serial clock high only while a byte is in flight
    a_r4_clk_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ph |-> busy);
endmodule

// File: rtl/qdw_strobe.sv
module qdw_strobe #(
    parameter int LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o,
    output logic done_o
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;
    logic          active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (!active) begin
            if (fire_i) begin
                active <= 1'b1;
                cnt    <= '0;
            end
        end else if (cnt == CW'(LEN - 1)) begin
            active <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign pulse_o = active;
    assign done_o  = active && (cnt == CW'(LEN - 1));

    // R10: a fire request during an active pulse must not restart the count
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !done_o) |=> (active && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/quad_dac_writer.sv
module quad_dac_writer
    import qdw_pkg::*;
#(
    parameter int DIV      = 4,
    parameter int LOAD_LEN = 2,
    parameter int CLR_LEN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic [CODE_W-1:0] req_code,
    input  logic              batch_mode,
    input  logic              clr_cmd,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic              frame_n,
    output logic              load_n,
    output logic              clear_n
);
    localparam int HALF  = DIV / 2;
    localparam int TMR_W = $clog2(DIV + 1);
    localparam int IDX_W = $clog2(FRAME_BYTES);

    seq_state_t         state, nxt;
    logic [TMR_W-1:0]   tmr;
    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   sel;
    logic [WORD_W-1:0]  word;
    logic [WORD_W-1:0]  shifted;
    logic [N_CHAN-1:0]  written;
    logic [CHAN_W-1:0]  chan_q;
    logic               fsync_q;
    logic               sh_start, sh_done, sh_busy;
    logic [BYTE_W-1:0]  sh_byte;
    logic               ld_fire, ld_pulse, ld_done;
    logic               cl_pulse, cl_done;
    logic               half_end, per_end, last_byte, want_load;

    assign half_end  = (tmr == TMR_W'(HALF - 1));
    assign per_end   = (tmr == TMR_W'(DIV - 1));
    assign last_byte = (idx == IDX_W'(FRAME_BYTES - 1));
    assign want_load = !batch_mode || (&written);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid)             nxt = ST_SYNC;
            ST_SYNC:  if (half_end)              nxt = ST_SHIFT;
            ST_SHIFT: if (sh_done && last_byte)  nxt = ST_RISE;
            ST_RISE:  if (per_end)               nxt = want_load ? ST_LOAD : ST_IDLE;
            ST_LOAD:  if (ld_done)               nxt = ST_IDLE;
            default:                             nxt = ST_IDLE;
        endcase
    end

    // Byte issue to the shift engine
    assign sh_start = ((state == ST_SYNC) && half_end) ||
                      ((state == ST_SHIFT) && sh_done && !last_byte);
    assign sel      = (state == ST_SYNC) ? '0 : idx + 1'b1;
    assign shifted  = word << (BYTE_W * sel);
    assign sh_byte  = shifted[WORD_W-1 -: BYTE_W];
    assign ld_fire  = (state == ST_RISE) && per_end && want_load;

    // Outputs and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsync_q <= 1'b1;
            tmr     <= '0;
            idx     <= '0;
            word    <= '0;
            chan_q  <= '0;
            written <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        word    <= pack_word(req_chan, req_code);
                        chan_q  <= req_chan;
                        fsync_q <= 1'b0;
                        tmr     <= '0;
                        idx     <= '0;
                    end
                end
                ST_SYNC: tmr <= tmr + 1'b1;
                ST_SHIFT: begin
                    if (sh_done) begin
                        if (last_byte) begin
                            fsync_q <= 1'b1;
                            tmr     <= '0;
                            written <= written | (N_CHAN'(1) << chan_q);
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_RISE: begin
                    tmr <= tmr + 1'b1;
                    if (per_end && want_load) written <= '0;
                end
                ST_LOAD: ;
                default: ;
            endcase
        end
    end

    qdw_shifter #(.HALF(HALF), .BYTE_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sh_start),
        .byte_i  (sh_byte),
        .sclk_o  (ser_clk),
        .sdo_o   (ser_dat),
        .busy_o  (sh_busy),
        .done_o  (sh_done)
    );

    qdw_strobe #(.LEN(LOAD_LEN)) u_load (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (ld_fire),
        .pulse_o (ld_pulse),
        .done_o  (ld_done)
    );

    qdw_strobe #(.LEN(CLR_LEN)) u_clear (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (clr_cmd),
        .pulse_o (cl_pulse),
        .done_o  (cl_done)
    );

    assign req_ready = (state == ST_IDLE);
    assign frame_n   = fsync_q;
    assign load_n    = !ld_pulse;
    assign clear_n   = !cl_pulse;

    // R2: a byte is only issued to a free shift engine
    a_r2_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> !sh_busy);

    // R4: serial clock toggles only inside a frame
    a_r4_clk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> !frame_n);

    // R7: load strobe never overlaps a frame
    a_r7_load_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> frame_n);

    // R7: load strobe at least two cycles wide
    a_r7_load_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_n) |=> !load_n);

    // R8: no acceptance while a frame is open
    a_r8_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |-> !req_ready);

    // R9: clear strobe is wider than one cycle and ends after its last count
    a_r9_clear_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clear_n) |=> !clear_n);
    a_r9_clear_ends: assert property (@(posedge clk) disable iff (!rst_n)
        cl_done |=> clear_n);
endmodule

// File: tb/quad_dac_writer_test.sv
module quad_dac_writer_test;
    localparam int DIV      = 4;
    localparam int LOAD_LEN = 2;
    localparam int CLR_LEN  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_chan = '0;
    logic [13:0] req_code = '0;
    logic        batch_mode = 1'b0;
    logic        clr_cmd = 1'b0;
    logic        ser_clk, ser_dat, frame_n, load_n, clear_n;

    always #2.5 clk = ~clk;

    quad_dac_writer #(.DIV(DIV), .LOAD_LEN(LOAD_LEN), .CLR_LEN(CLR_LEN)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_code(req_code), .batch_mode(batch_mode),
        .clr_cmd(clr_cmd), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .frame_n(frame_n), .load_n(load_n), .clear_n(clear_n)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        end
    endtask

    // Port monitor, sampled on falling system clock edges
    int cyc = 0;
    logic p_clk = 0, p_dat = 0, p_fs = 1, p_ld = 1, p_cl = 1;
    int bitcnt = 0, frames = 0, fr_bits = 0;
    logic [23:0] rxw = '0, fr_word = '0;
    int ld_cnt = 0, ld_run = 0, ld_w = 0, ld_gap = 0, rise_cyc = 0;
    int cl_cnt = 0, cl_run = 0, cl_w = 0;
    int min_per = 1000, last_rise = -1, stab_err = 0, stray = 0;
    int fall_cyc = 0, min_lead = 1000;
    bit first_rise = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (p_fs && !frame_n) begin
                bitcnt = 0; rxw = '0; fall_cyc = cyc; first_rise = 1;
            end
            if (!p_clk && ser_clk) begin
                if (frame_n) stray++;
                if (first_rise) begin
                    if (cyc - fall_cyc < min_lead) min_lead = cyc - fall_cyc;
                    first_rise = 0;
                end
                if (last_rise >= 0 && cyc - last_rise < min_per) min_per = cyc - last_rise;
                last_rise = cyc;
            end
            if (p_clk && (ser_dat !== p_dat)) stab_err++;
            if (p_clk && !ser_clk && !frame_n) begin
                rxw = {rxw[22:0], ser_dat};
                bitcnt++;
            end
            if (!p_fs && frame_n) begin
                fr_word = rxw; fr_bits = bitcnt; frames++; rise_cyc = cyc;
            end
            if (p_ld && !load_n) ld_gap = cyc - rise_cyc;
            if (!load_n) ld_run++;
            else if (ld_run > 0) begin ld_w = ld_run; ld_cnt++; ld_run = 0; end
            if (!clear_n) cl_run++;
            else if (cl_run > 0) begin cl_w = cl_run; cl_cnt++; cl_run = 0; end
            p_clk = ser_clk; p_dat = ser_dat; p_fs = frame_n; p_ld = load_n; p_cl = clear_n;
        end
    end

    task automatic send(input int ch, input int code, input bit exp_load, input string req);
        int ld0;
        int fr0;
        logic [23:0] exp;
        ld0 = ld_cnt;
        fr0 = frames;
        exp = (24'(ch) << 20) | 24'(code);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_chan = 2'(ch); req_code = 14'(code);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R8", "ready after accept", int'(req_ready), 0);
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        check(frames == fr0 + 1, "R2", "frame count", frames, fr0 + 1);
        check(fr_word == exp, "R2", "frame word", int'(fr_word), int'(exp));
        check(fr_bits == 24, "R2", "falling edges per frame", fr_bits, 24);
        check(ld_cnt == ld0 + int'(exp_load), req, "load pulses", ld_cnt, ld0 + int'(exp_load));
        if (exp_load) begin
            check(ld_w == LOAD_LEN, "R7", "load width", ld_w, LOAD_LEN);
            check(ld_gap >= DIV, "R7", "load gap after frame", ld_gap, DIV);
        end
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr_cmd = 1'b1;
        @(negedge clk);
        clr_cmd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        report();
        $finish;
    end

    initial begin
        int c0;
        int fr0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(frame_n == 1'b1, "R1", "frame_n", int'(frame_n), 1);
        check(load_n == 1'b1, "R1", "load_n", int'(load_n), 1);
        check(clear_n == 1'b1, "R1", "clear_n", int'(clear_n), 1);
        check(ser_clk == 1'b0, "R1", "ser_clk", int'(ser_clk), 0);
        check(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);

        // R5: immediate mode, every channel with a sweep of codes
        for (int ch = 0; ch < 4; ch++) begin
            send(ch, 0, 1, "R5");
            send(ch, 16'h3FFF, 1, "R5");
            send(ch, 16'h2AAA, 1, "R5");
            send(ch, 16'h1555, 1, "R5");
            for (int k = 0; k < 14; k++) send(ch, 1 << k, 1, "R5");
        end

        // R8: request held while busy is not taken twice
        fr0 = frames;
        @(negedge clk);
        req_valid = 1'b1; req_chan = 2'd2; req_code = 14'h0123;
        @(negedge clk);
        req_chan = 2'd1; req_code = 14'h3210;
        repeat (20) @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        repeat (40) @(negedge clk);
        check(frames == fr0 + 1, "R8", "frames after held request", frames, fr0 + 1);
        check(fr_word == 24'h200123, "R8", "word of held request", int'(fr_word), 24'h200123);

        // R6: batch mode
        batch_mode = 1'b1;
        send(0, 14'h0011, 0, "R6");
        send(1, 14'h0022, 0, "R6");
        send(2, 14'h0033, 0, "R6");
        send(1, 14'h0044, 0, "R6");
        send(3, 14'h0055, 1, "R6");
        send(3, 14'h0066, 0, "R6");
        send(2, 14'h0077, 0, "R6");
        send(1, 14'h0088, 0, "R6");
        send(0, 14'h0099, 1, "R6");
        batch_mode = 1'b0;

        // R9: clear while idle
        c0 = cl_cnt;
        pulse_clear();
        check(clear_n == 1'b0, "R9", "clear starts next cycle", int'(clear_n), 0);
        repeat (CLR_LEN + 3) @(negedge clk);
        check(cl_cnt == c0 + 1, "R9", "clear pulses", cl_cnt, c0 + 1);
        check(cl_w == CLR_LEN, "R9", "clear width", cl_w, CLR_LEN);

        // R10: second command during the pulse is ignored
        c0 = cl_cnt;
        pulse_clear();
        clr_cmd = 1'b1;
        @(negedge clk);
        clr_cmd = 1'b0;
        repeat (CLR_LEN + 4) @(negedge clk);
        check(cl_cnt == c0 + 1, "R10", "clear pulses", cl_cnt, c0 + 1);
        check(cl_w == CLR_LEN, "R10", "clear width", cl_w, CLR_LEN);

        // R9: clear during a frame leaves the frame intact
        c0 = cl_cnt;
        fork
            send(1, 14'h1234, 1, "R9");
            begin
                repeat (40) @(negedge clk);
                pulse_clear();
            end
        join
        repeat (CLR_LEN + 2) @(negedge clk);
        check(cl_cnt == c0 + 1, "R9", "clear during frame", cl_cnt, c0 + 1);

        // R3 / R4: timing figures gathered by the monitor
        check(min_per == DIV, "R3", "serial clock period", min_per, DIV);
        check(stab_err == 0, "R3", "data changes while clock high", stab_err, 0);
        check(stray == 0, "R4", "clock edges outside frame", stray, 0);
        check(min_lead >= DIV / 2, "R4", "frame lead before first edge", min_lead, DIV / 2);

        report();
        $finish;
    end
endmodule